// File: doc/BRIEF.md
# Dual-Mode Auto-Reload Timer

This block is a 16-bit timer made of two 8-bit count bytes. It runs in one of two modes. In the first, the two bytes form a single 16-bit counter that restarts from a 16-bit reload value. In the second, split mode, each byte is a separate 8-bit counter with its own reload byte. Each byte picks its count rate. The choices are every system clock cycle or an alternate rate. The alternate rate is either the system clock divided by 12 or an external clock divided by 8. The external clock is brought into the system clock domain before it is divided. All count rates are single-cycle enables on the system clock.

Overflows set sticky flags. The flags and the enables together drive one interrupt request. A capture mode copies the live count into the reload registers on each rising edge of a slow oscillator input. Software reaches the block through a simple register write and read port with six byte-wide registers.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low.
- R2: With split clear, the bytes count as one 16-bit value {hi,lo} on each enabled tick. On a tick at 0xFFFF, the count loads {reload_hi,reload_lo} and the high flag (control bit 7) is set.
- R3: The low flag (control bit 6) is set on every 0xFF to 0x00 wrap of the low byte, in both modes. With split clear, a low-byte wrap that is not a full 16-bit wrap leaves the low byte at 0x00 and increments the high byte.
- R4: With split set, each byte counts on its own. On a wrap from 0xFF, each byte loads its own reload byte. The high byte sets the high flag and the low byte sets the low flag.
- R5: The run bit (control bit 2) gates the whole counter when split is clear. When split is set, it gates only the high byte and the low byte keeps counting.
- R6: Clock select register (address 1): bit 0 is for the low byte and bit 1 is for the high byte. A value of 1 counts every cycle and 0 counts on the alternate tick. Control bit 0 picks the alternate tick: 0 gives one tick per 12 cycles, and 1 gives one tick per 8 rising edges of `ext_clk_in` after a two-flop synchroniser. With split clear, the low-byte select governs the whole counter.
- R7: Hardware never clears a flag. A control write loads bits 7 and 6 into the flags. If hardware sets a flag in the same cycle that software writes it, the flag ends up set.
- R8: `irq` is high when `irq_en_global` is high and either the high flag is set, or control bit 5 (low interrupt enable) and the low flag are both set.
- R9: With control bit 4 (capture enable) set, a synchronised rising edge of `slow_osc_in` copies {hi,lo} into {reload_hi,reload_lo} and sets the high flag. With bit 4 clear, the edge has no effect.
- R10: Register map: 0 control, 1 clock select, 2 reload low, 3 reload high, 4 count low, 5 count high. Control layout: bit 7 high flag, bit 6 low flag, bit 5 low interrupt enable, bit 4 capture enable, bit 3 split, bit 2 run, bit 1 unused (reads 0), bit 0 alternate select. Clock select bits 7..2 read 0.
- R11: A software write to a count byte takes priority over that byte's increment or reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Combinational read data |
| irq_en_global | input | 1 | Global interrupt enable for this timer |
| ext_clk_in | input | 1 | External clock, asynchronous |
| slow_osc_in | input | 1 | Slow oscillator for capture, asynchronous |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check the following on every cycle:
- A stopped 16-bit counter holds its value.
- In split mode, the low byte steps by one on each tick.
- A full 16-bit wrap sets the high flag.
- The flags fall only on a control write.
- A capture copies the count into the reload registers.
- A set high flag with the global enable raises the interrupt.
- The divide-by-12 tick never fires on two cycles in a row.

Some behaviours only the bench scenarios can show:
- The exact wrap and reload values.
- A hardware flag set winning over a clearing write in the same cycle.
- The tick counts over a window at the divided rates.
- The external divide-by-8 path.
- The register read layout.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;

  localparam int BYTE_W = 8;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_CLKSEL = 3'd1;
  localparam logic [2:0] REG_RL_LO  = 3'd2;
  localparam logic [2:0] REG_RL_HI  = 3'd3;
  localparam logic [2:0] REG_CNT_LO = 3'd4;
  localparam logic [2:0] REG_CNT_HI = 3'd5;

  // control register bit positions
  localparam int CB_XSEL  = 0;
  localparam int CB_RUN   = 2;
  localparam int CB_SPLIT = 3;
  localparam int CB_CAP   = 4;
  localparam int CB_LIE   = 5;
  localparam int CB_FLO   = 6;
  localparam int CB_FHI   = 7;

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int PRE_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk_in,
  input  logic slow_osc_in,
  input  logic ext_sel,
  output logic alt_tick,
  output logic slow_rise
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);
  localparam logic [EW-1:0] EXT_LAST = EW'(EXT_DIV - 1);

  logic          ext_rise;
  logic [PW-1:0] pre_q, pre_d;
  logic [EW-1:0] ext_q, ext_d;
  logic          pre_tick, ext_tick;

  sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk_in), .rise(ext_rise));

  sync_edge #(.STAGES(SYNC_STAGES)) u_slow_sync (
    .clk(clk), .rst_n(rst_n), .din(slow_osc_in), .rise(slow_rise));

  always_comb begin
    pre_tick = (pre_q == PRE_LAST);
    pre_d    = pre_tick ? '0 : pre_q + PW'(1);
    ext_tick = ext_rise && (ext_q == EXT_LAST);
    ext_d    = ext_q;
    if (ext_rise) ext_d = (ext_q == EXT_LAST) ? '0 : ext_q + EW'(1);
    alt_tick = ext_sel ? ext_tick : pre_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ext_q <= '0;
    end else begin
      pre_q <= pre_d;
      ext_q <= ext_d;
    end
  end

  // R6: the divided system tick is never asserted on consecutive cycles
  assert_pre_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick);
endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_lo,
  input  logic         tick_hi,
  input  logic         split,
  input  logic         run,
  input  logic         cap_en,
  input  logic         slow_rise,
  input  logic [W-1:0] wdata,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic         wr_rl_lo,
  input  logic         wr_rl_hi,
  input  logic         wr_flags,
  input  logic         wflag_hi,
  input  logic         wflag_lo,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic [W-1:0] rl_lo,
  output logic [W-1:0] rl_hi,
  output logic         flag_hi,
  output logic         flag_lo
);
  logic [W-1:0] lo_d, hi_d, rl_lo_d, rl_hi_d;
  logic         fhi_d, flo_d;
  logic         lo_max, hi_max, lo_step, hi_step, lo_wrap, hi_set;
  logic         lo_load, hi_load, cap;

  always_comb begin
    lo_max  = (cnt_lo == '1);
    hi_max  = (cnt_hi == '1);
    if (split) begin
      lo_step = tick_lo;
      hi_step = tick_hi & run;
      lo_wrap = lo_step & lo_max;
      hi_set  = hi_step & hi_max;
      lo_load = lo_wrap;
      hi_load = hi_set;
    end else begin
      lo_step = tick_lo & run;
      lo_wrap = lo_step & lo_max;
      hi_step = lo_wrap;
      hi_set  = lo_wrap & hi_max;
      lo_load = hi_set;
      hi_load = hi_set;
    end

    lo_d = cnt_lo;
    if (wr_lo)        lo_d = wdata;
    else if (lo_step) lo_d = lo_load ? rl_lo : cnt_lo + W'(1);

    hi_d = cnt_hi;
    if (wr_hi)        hi_d = wdata;
    else if (hi_step) hi_d = hi_load ? rl_hi : cnt_hi + W'(1);

    cap     = cap_en & slow_rise;
    rl_lo_d = cap ? cnt_lo : (wr_rl_lo ? wdata : rl_lo);
    rl_hi_d = cap ? cnt_hi : (wr_rl_hi ? wdata : rl_hi);

    fhi_d = hi_set | cap | (wr_flags ? wflag_hi : flag_hi);
    flo_d = lo_wrap | (wr_flags ? wflag_lo : flag_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo  <= '0;
      cnt_hi  <= '0;
      rl_lo   <= '0;
      rl_hi   <= '0;
      flag_hi <= 1'b0;
      flag_lo <= 1'b0;
    end else begin
      cnt_lo  <= lo_d;
      cnt_hi  <= hi_d;
      rl_lo   <= rl_lo_d;
      rl_hi   <= rl_hi_d;
      flag_hi <= fhi_d;
      flag_lo <= flo_d;
    end
  end

  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && !run && !wr_lo && !wr_hi) |=> $stable({cnt_hi, cnt_lo}));

  assert_split_lo_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (split && tick_lo && !wr_lo && cnt_lo != '1) |=> cnt_lo == $past(cnt_lo) + W'(1));

  assert_full_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && run && tick_lo && cnt_lo == '1 && cnt_hi == '1) |=> flag_hi);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flag_hi) || $fell(flag_lo)) |-> $past(wr_flags));

  assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && slow_rise) |=> {rl_hi, rl_lo} == $past({cnt_hi, cnt_lo}));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import dual_timer_pkg::*;
#(
  parameter int PRE_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              irq_en_global,
  input  logic              ext_clk_in,
  input  logic              slow_osc_in,
  output logic              irq
);
  logic lie_q, cap_q, split_q, run_q, xsel_q, sel_lo_q, sel_hi_q;
  logic lie_d, cap_d, split_d, run_d, xsel_d, sel_lo_d, sel_hi_d;
  logic wr_ctrl, wr_sel, wr_rl_lo, wr_rl_hi, wr_lo, wr_hi;
  logic alt_tick, slow_rise, tick_lo, tick_hi;
  logic [BYTE_W-1:0] cnt_lo, cnt_hi, rl_lo, rl_hi;
  logic flag_hi, flag_lo;

  always_comb begin
    wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
    wr_sel   = wr_en && (wr_addr == REG_CLKSEL);
    wr_rl_lo = wr_en && (wr_addr == REG_RL_LO);
    wr_rl_hi = wr_en && (wr_addr == REG_RL_HI);
    wr_lo    = wr_en && (wr_addr == REG_CNT_LO);
    wr_hi    = wr_en && (wr_addr == REG_CNT_HI);

    lie_d    = wr_ctrl  ? wr_data[CB_LIE]   : lie_q;
    cap_d    = wr_ctrl  ? wr_data[CB_CAP]   : cap_q;
    split_d  = wr_ctrl  ? wr_data[CB_SPLIT] : split_q;
    run_d    = wr_ctrl  ? wr_data[CB_RUN]   : run_q;
    xsel_d   = wr_ctrl  ? wr_data[CB_XSEL]  : xsel_q;
    sel_lo_d = wr_sel   ? wr_data[0]        : sel_lo_q;
    sel_hi_d = wr_sel   ? wr_data[1]        : sel_hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lie_q    <= 1'b0;
      cap_q    <= 1'b0;
      split_q  <= 1'b0;
      run_q    <= 1'b0;
      xsel_q   <= 1'b0;
      sel_lo_q <= 1'b0;
      sel_hi_q <= 1'b0;
    end else begin
      lie_q    <= lie_d;
      cap_q    <= cap_d;
      split_q  <= split_d;
      run_q    <= run_d;
      xsel_q   <= xsel_d;
      sel_lo_q <= sel_lo_d;
      sel_hi_q <= sel_hi_d;
    end
  end

  tick_gen #(.PRE_DIV(PRE_DIV), .EXT_DIV(EXT_DIV), .SYNC_STAGES(SYNC_STAGES)) u_ticks (
    .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .slow_osc_in(slow_osc_in),
    .ext_sel(xsel_q), .alt_tick(alt_tick), .slow_rise(slow_rise));

  assign tick_lo = sel_lo_q | alt_tick;
  assign tick_hi = sel_hi_q | alt_tick;

  count_core #(.W(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_lo(tick_lo), .tick_hi(tick_hi),
    .split(split_q), .run(run_q), .cap_en(cap_q), .slow_rise(slow_rise),
    .wdata(wr_data), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_rl_lo(wr_rl_lo),
    .wr_rl_hi(wr_rl_hi), .wr_flags(wr_ctrl), .wflag_hi(wr_data[CB_FHI]),
    .wflag_lo(wr_data[CB_FLO]), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .rl_lo(rl_lo), .rl_hi(rl_hi), .flag_hi(flag_hi), .flag_lo(flag_lo));

  always_comb begin
    rd_data = '0;
    if (rd_addr == REG_CTRL)
      rd_data = {flag_hi, flag_lo, lie_q, cap_q, split_q, run_q, 1'b0, xsel_q};
    else if (rd_addr == REG_CLKSEL) rd_data = {6'b0, sel_hi_q, sel_lo_q};
    else if (rd_addr == REG_RL_LO)  rd_data = rl_lo;
    else if (rd_addr == REG_RL_HI)  rd_data = rl_hi;
    else if (rd_addr == REG_CNT_LO) rd_data = cnt_lo;
    else if (rd_addr == REG_CNT_HI) rd_data = cnt_hi;
  end

  assign irq = irq_en_global & (flag_hi | (lie_q & flag_lo));

  assert_irq_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_global && flag_hi) |-> irq);
endmodule

// File: tb/dual_reload_timer_test.sv
`timescale 1ns/1ps
module dual_reload_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic       irq_en_global = 1'b0;
  logic       ext_clk_in = 1'b0;
  logic       slow_osc_in = 1'b0;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dual_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_en_global(irq_en_global),
    .ext_clk_in(ext_clk_in), .slow_osc_in(slow_osc_in), .irq(irq));

  // {is_write, addr, data, expected read}
  localparam int NVEC = 20;
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 3'd2, 8'hA5, 8'h00}, {1'b0, 3'd2, 8'h00, 8'hA5},
    {1'b1, 3'd3, 8'h3C, 8'h00}, {1'b0, 3'd3, 8'h00, 8'h3C},
    {1'b1, 3'd4, 8'h12, 8'h00}, {1'b0, 3'd4, 8'h00, 8'h12},
    {1'b1, 3'd5, 8'h34, 8'h00}, {1'b0, 3'd5, 8'h00, 8'h34},
    {1'b1, 3'd0, 8'h02, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h00},
    {1'b1, 3'd0, 8'h31, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h31},
    {1'b1, 3'd0, 8'hC0, 8'h00}, {1'b0, 3'd0, 8'h00, 8'hC0},
    {1'b1, 3'd1, 8'hFF, 8'h00}, {1'b0, 3'd1, 8'h00, 8'h03},
    {1'b1, 3'd0, 8'h00, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h00}, {1'b0, 3'd1, 8'h00, 8'h00}
  };

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== e) begin
      fails++;
      $display("FAIL %s: reg %0d got %02h expected %02h", tag, a, rd_data, e);
    end
  endtask

  task automatic chk_irq(input logic e, input string tag);
    #1;
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    for (int i = 0; i < 6; i++) chk(3'(i), 8'h00, "R1 reset");
    chk_irq(1'b0, "R1 reset irq");

    // R10 register map walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
      else            chk(VEC[i][18:16], VEC[i][7:0], "R10 regmap");
    end

    // R2 full 16-bit wrap with reload
    wr(3'd1, 8'h03);
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    wr(3'd4, 8'hFD); wr(3'd5, 8'hFF);
    wr(3'd0, 8'h04);
    tick(2);
    chk(3'd4, 8'hFF, "R2 pre-wrap lo"); chk(3'd5, 8'hFF, "R2 pre-wrap hi");
    chk(3'd0, 8'h04, "R2 no flag yet");
    tick(1);
    chk(3'd4, 8'h34, "R2 reload lo"); chk(3'd5, 8'h12, "R2 reload hi");
    chk(3'd0, 8'hC4, "R2 R3 flags set");
    wr(3'd0, 8'h00);
    tick(5);
    chk(3'd4, 8'h35, "R5 stopped lo"); chk(3'd5, 8'h12, "R5 stopped hi");

    // R3 low wrap inside 16-bit mode
    wr(3'd4, 8'hFE); wr(3'd5, 8'h00);
    wr(3'd0, 8'h04);
    tick(2);
    chk(3'd4, 8'h00, "R3 lo no reload"); chk(3'd5, 8'h01, "R3 hi carry");
    chk(3'd0, 8'h44, "R3 low flag only");
    wr(3'd0, 8'h00);

    // R4 R5 split mode
    wr(3'd2, 8'hF0); wr(3'd3, 8'h80);
    wr(3'd4, 8'hFE); wr(3'd5, 8'hFD);
    wr(3'd0, 8'h08);
    tick(2);
    chk(3'd4, 8'hF0, "R4 split lo reload"); chk(3'd5, 8'hFD, "R5 hi gated");
    chk(3'd0, 8'h48, "R4 low flag");
    wr(3'd0, 8'h0C);
    tick(3);
    chk(3'd4, 8'hF4, "R4 lo runs"); chk(3'd5, 8'h80, "R4 hi reload");
    chk(3'd0, 8'h8C, "R4 high flag");
    wr(3'd0, 8'h00);

    // R7 hardware set beats clearing write; R11 write beats increment
    wr(3'd4, 8'hFF);
    wr(3'd0, 8'h08);
    wr(3'd0, 8'h08);
    chk(3'd0, 8'h48, "R7 hw set wins");
    chk(3'd4, 8'hF0, "R4 lo wrap reload");
    wr(3'd4, 8'h10);
    chk(3'd4, 8'h10, "R11 write override");
    wr(3'd0, 8'h00);

    // R8 interrupt combination
    irq_en_global = 1'b1;
    wr(3'd0, 8'h40); chk_irq(1'b0, "R8 low flag no enable");
    wr(3'd0, 8'h60); chk_irq(1'b1, "R8 low flag enabled");
    irq_en_global = 1'b0; chk_irq(1'b0, "R8 global off");
    irq_en_global = 1'b1;
    wr(3'd0, 8'h80); chk_irq(1'b1, "R8 high flag");
    wr(3'd0, 8'h00); chk_irq(1'b0, "R8 flags clear");

    // R9 capture disabled then enabled
    slow_osc_in = 1'b1; tick(5);
    chk(3'd2, 8'hF0, "R9 no capture lo"); chk(3'd3, 8'h80, "R9 no capture hi");
    chk(3'd0, 8'h00, "R9 no flag");
    slow_osc_in = 1'b0; tick(4);
    wr(3'd4, 8'h78); wr(3'd5, 8'h56);
    wr(3'd0, 8'h10);
    slow_osc_in = 1'b1; tick(5);
    chk(3'd2, 8'h78, "R9 capture lo"); chk(3'd3, 8'h56, "R9 capture hi");
    chk(3'd0, 8'h90, "R9 capture flag");
    chk_irq(1'b1, "R9 capture irq");
    wr(3'd0, 8'h00);
    irq_en_global = 1'b0;

    // R6 divide-by-12 alternate tick
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd0, 8'h04);
    tick(120);
    chk(3'd4, 8'h0A, "R6 div12 lo"); chk(3'd5, 8'h00, "R6 div12 hi");
    wr(3'd0, 8'h00);

    // R6 external divide-by-8, low select governs 16-bit mode
    wr(3'd1, 8'h02);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd0, 8'h05);
    for (int e = 0; e < 24; e++) begin
      ext_clk_in = 1'b1; tick(2);
      ext_clk_in = 1'b0; tick(2);
    end
    tick(6);
    chk(3'd4, 8'h03, "R6 ext div8 lo"); chk(3'd5, 8'h00, "R6 ext div8 hi");
    wr(3'd0, 8'h01);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule